// File: doc/BRIEF.md
# Bit-Plane Pointer and Fetch Address Generator

This block keeps one start-address pointer for each of six bit-planes and turns them into a stream of word fetch addresses for a display fetch engine. Software or a list-driven coprocessor loads a pointer through a register-write port. The pointer is a 19-bit byte address. It can be loaded as two 16-bit halves or as one 32-bit write. The write port carries a 9-bit byte offset, so it addresses each half register by its own offset.

The fetch engine presents a plane number and a fetch strobe. One cycle later the block returns that plane's current byte address. At the same edge it steps the pointer on by one 16-bit word. A plane's words lie back to back: a 320-pixel line takes 40 bytes, and 200 lines end 7998 bytes past the start. Successive strobes on one plane therefore walk through the whole plane with no gaps. The pointers are normally reloaded once per frame.

Top module: `bpl_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, fetch_valid and fetch_err are 0 and every pointer is 0, so the first fetch of any plane returns address 0.
- R2: A 16-bit write (wr_long=0) to offset 0x0E0+4k, where k is 0 to 5 for planes 1 to 6, loads pointer bits 18:16 from wr_data[2:0]. Data bits 15:3 are ignored and pointer bits 15:0 keep their value.
- R3: A 16-bit write to offset 0x0E2+4k loads pointer bits 15:1 from wr_data[15:1]. Pointer bit 0 is always 0, and bits 18:16 keep their value.
- R4: A 32-bit write (wr_long=1) to offset 0x0E0+4k loads the whole pointer in one cycle: bits 18:16 from wr_data[18:16] and bits 15:1 from wr_data[15:1]. A 32-bit write to a low-half offset 0x0E2+4k changes nothing.
- R5: Writes to offsets outside 0x0E0 to 0x0F7, and writes to odd offsets, change no pointer.
- R6: A fetch strobe with fetch_plane in 1 to 6 makes fetch_valid 1 in the next cycle, with fetch_addr equal to that plane's pointer before the strobe. The pointer then holds its old value plus 2.
- R7: The pointer wraps modulo 2^19, so a fetch at 0x7FFFE leaves the pointer at 0x00000.
- R8: If a register write and a fetch hit the same plane in the same cycle, the write decides the new pointer and no increment is applied. The fetch still returns the pre-write address.
- R9: A fetch strobe with fetch_plane equal to 0 or 7 raises fetch_err for the next cycle with fetch_valid 0, and changes no pointer.
- R10: 4000 consecutive fetches from start S return S, S+2, and so on. The 21st fetch returns S+40, which is the first word of the second line, and the 4000th fetch returns S+7998.
- R11: A fetch on one plane never changes the pointer of any other plane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_long | input | 1 | 1: 32-bit write, 0: 16-bit write using wr_data[15:0] |
| wr_addr | input | 9 | Byte offset of the write |
| wr_data | input | 32 | Write data; for a 32-bit write, the high word is bits 31:16 |
| fetch_en | input | 1 | Fetch strobe |
| fetch_plane | input | 3 | Plane number, 1 to 6 |
| fetch_valid | output | 1 | fetch_addr holds the result of last cycle's strobe |
| fetch_addr | output | 19 | Returned byte address |
| fetch_err | output | 1 | Last cycle's strobe named an invalid plane |

## Verification
The hardest state to reach from the ports is a pointer near the top of the 19-bit space, where the increment wraps. A walk from reset would take about 262,000 fetches to get there. The bench instead loads 0x7FFFC with a single 32-bit write and fetches three times. It also lines up a write and a fetch to the same plane in one cycle to exercise the write-over-increment priority. Two full 4000-word plane scans are compared every cycle against a behavioural pointer model.

// File: rtl/bpl_pkg.sv
// Package: shared widths and helpers for the bit-plane pointer block.
// Assumes byte addressing with 16-bit words, so pointer bit 0 is never stored.
package bpl_pkg;
    localparam int unsigned BPL_WORD_W = 16;   // width of one register half
    localparam int unsigned BPL_OFF_W  = 9;    // width of the register byte offset

    // Returns 1 when a 1-based plane number names an existing plane.
    function automatic logic plane_ok(input logic [7:0] num, input int unsigned planes);
        return (num != 8'd0) && (int'(num) <= int'(planes));
    endfunction
endpackage

// File: rtl/bpl_reg_decode.sv
// Module: bpl_reg_decode
// Turns a register byte offset into a plane index and a half selector.
// Assumes a block of NUM_PLANES 4-byte slots starting at BASE: the high half at
// +0 and the low half at +2. Odd offsets and offsets outside the block give no hit.
module bpl_reg_decode
    import bpl_pkg::*;
#(
    parameter int unsigned NUM_PLANES = 6,
    parameter logic [BPL_OFF_W-1:0] BASE = 9'h0E0,
    localparam int unsigned IDX_W = $clog2(NUM_PLANES)
) (
    input  logic [BPL_OFF_W-1:0] addr,
    output logic                 hit,
    output logic [IDX_W-1:0]     plane_idx,
    output logic                 is_low
);
    localparam int unsigned SPAN = 4 * NUM_PLANES;

    logic [BPL_OFF_W-1:0] rel;

    // Offset relative to the start of the pointer block.
    always_comb rel = addr - BASE;

    // Hit test and field split of the relative offset.
    always_comb begin
        hit       = (addr >= BASE) && (32'(rel) < SPAN) && !addr[0];
        plane_idx = IDX_W'(rel[BPL_OFF_W-1:2]);
        is_low    = rel[1];
    end
endmodule

// File: rtl/bpl_ptr_slot.sv
// Module: bpl_ptr_slot
// Holds one plane pointer as a word address (bit 0 implied zero).
// Assumes at most one write strobe is active per cycle; any write wins over inc.
module bpl_ptr_slot
    import bpl_pkg::*;
#(
    parameter int unsigned ADDR_W = 19,
    localparam int unsigned HI_W = ADDR_W - BPL_WORD_W,
    localparam int unsigned PW   = ADDR_W - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_hi,
    input  logic                    wr_lo,
    input  logic                    wr_full,
    input  logic [2*BPL_WORD_W-1:0] wr_data,
    input  logic                    inc,
    output logic [ADDR_W-1:0]       ptr
);
    logic [PW-1:0] word_q;

    // Pointer register: reset, register loads, then the fetch step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (wr_full) begin
            word_q <= wr_data[ADDR_W-1:1];
        end else if (wr_hi) begin
            word_q[PW-1:BPL_WORD_W-1] <= wr_data[HI_W-1:0];
        end else if (wr_lo) begin
            word_q[BPL_WORD_W-2:0] <= wr_data[BPL_WORD_W-1:1];
        end else if (inc) begin
            word_q <= word_q + PW'(1);
        end
    end

    // Byte address view of the word pointer.
    always_comb ptr = {word_q, 1'b0};
endmodule

// File: rtl/bpl_fetch_port.sv
// Module: bpl_fetch_port
// Registers the selected plane's pointer as the fetch result and flags bad indexes.
// Assumes plane numbers are 1-based; the increment strobe goes back to the slots.
module bpl_fetch_port
    import bpl_pkg::*;
#(
    parameter int unsigned NUM_PLANES = 6,
    parameter int unsigned ADDR_W     = 19,
    localparam int unsigned NUM_W = $clog2(NUM_PLANES + 1),
    localparam int unsigned IDX_W = $clog2(NUM_PLANES)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               fetch_en,
    input  logic [NUM_W-1:0]                   fetch_plane,
    input  logic [NUM_PLANES-1:0][ADDR_W-1:0]  ptr_vec,
    output logic [NUM_PLANES-1:0]              inc_vec,
    output logic                               fetch_valid,
    output logic [ADDR_W-1:0]                  fetch_addr,
    output logic                               fetch_err
);
    logic             good;
    logic [IDX_W-1:0] idx;

    // Validity and zero-based index of the requested plane.
    always_comb begin
        good = fetch_en && plane_ok(8'(fetch_plane), NUM_PLANES);
        idx  = IDX_W'(fetch_plane - NUM_W'(1));
    end

    // One-hot increment request toward the pointer slots.
    for (genvar k = 0; k < NUM_PLANES; k++) begin : g_inc
        assign inc_vec[k] = good && (idx == IDX_W'(k));
    end

    // Output register: returned address, valid and error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_valid <= 1'b0;
            fetch_err   <= 1'b0;
            fetch_addr  <= '0;
        end else begin
            fetch_valid <= good;
            fetch_err   <= fetch_en && !good;
            if (good) fetch_addr <= ptr_vec[idx];
        end
    end
endmodule

// File: rtl/bpl_addr_gen.sv
// Module: bpl_addr_gen (top)
// Bit-plane pointer registers with a self-advancing word fetch port.
// Assumes a 9-bit register byte offset and 32-bit write data, where a 16-bit write
// uses bits 15:0. A register write to a plane overrides that plane's fetch step.
module bpl_addr_gen
    import bpl_pkg::*;
#(
    parameter int unsigned NUM_PLANES = 6,
    parameter int unsigned ADDR_W     = 19,
    parameter logic [8:0]  BASE       = 9'h0E0,
    localparam int unsigned NUM_W = $clog2(NUM_PLANES + 1),
    localparam int unsigned IDX_W = $clog2(NUM_PLANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_long,
    input  logic [8:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              fetch_en,
    input  logic [NUM_W-1:0]  fetch_plane,
    output logic              fetch_valid,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_err
);
    logic                              dec_hit;
    logic [IDX_W-1:0]                  dec_idx;
    logic                              dec_low;
    logic                              wr_hit;
    logic [NUM_PLANES-1:0][ADDR_W-1:0] ptr_vec;
    logic [NUM_PLANES-1:0]             inc_vec;

    bpl_reg_decode #(
        .NUM_PLANES (NUM_PLANES),
        .BASE       (BASE)
    ) u_dec (
        .addr      (wr_addr),
        .hit       (dec_hit),
        .plane_idx (dec_idx),
        .is_low    (dec_low)
    );

    // A write is accepted unless it is a 32-bit write aimed at a low half.
    always_comb wr_hit = wr_en && dec_hit && !(wr_long && dec_low);

    for (genvar k = 0; k < NUM_PLANES; k++) begin : g_slot
        logic sel;
        // Per-plane write select.
        always_comb sel = wr_hit && (dec_idx == IDX_W'(k));

        bpl_ptr_slot #(
            .ADDR_W (ADDR_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hi   (sel && !dec_low && !wr_long),
            .wr_lo   (sel && dec_low),
            .wr_full (sel && wr_long),
            .wr_data (wr_data),
            .inc     (inc_vec[k]),
            .ptr     (ptr_vec[k])
        );
    end

    bpl_fetch_port #(
        .NUM_PLANES (NUM_PLANES),
        .ADDR_W     (ADDR_W)
    ) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_en    (fetch_en),
        .fetch_plane (fetch_plane),
        .ptr_vec     (ptr_vec),
        .inc_vec     (inc_vec),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .fetch_err   (fetch_err)
    );
endmodule

// File: rtl/bpl_addr_gen_chk.sv
// Module: bpl_addr_gen_chk
// Temporal checks on the fetch port and pointer array, bound into bpl_addr_gen.
module bpl_addr_gen_chk #(
    parameter int unsigned NUM_PLANES = 6,
    parameter int unsigned ADDR_W     = 19,
    localparam int unsigned NUM_W = $clog2(NUM_PLANES + 1),
    localparam int unsigned IDX_W = $clog2(NUM_PLANES)
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              fetch_en,
    input logic [NUM_W-1:0]                  fetch_plane,
    input logic                              fetch_valid,
    input logic [ADDR_W-1:0]                 fetch_addr,
    input logic                              fetch_err,
    input logic                              wr_hit,
    input logic [NUM_PLANES-1:0][ADDR_W-1:0] ptr_vec
);
    logic             good;
    logic [IDX_W-1:0] idx;
    logic [ADDR_W-1:0] cur_ptr;
    logic             adv_q;
    logic [IDX_W-1:0] idx_q;
    logic [ADDR_W-1:0] ptr_q;

    // Requested plane, as seen by the checker.
    always_comb begin
        good    = fetch_en && (fetch_plane != '0) && (32'(fetch_plane) <= NUM_PLANES);
        idx     = IDX_W'(fetch_plane - NUM_W'(1));
        cur_ptr = good ? ptr_vec[idx] : '0;
    end

    // Remember an unopposed fetch so the step can be checked one cycle on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adv_q <= 1'b0;
            idx_q <= '0;
            ptr_q <= '0;
        end else begin
            adv_q <= good && !wr_hit;
            idx_q <= idx;
            ptr_q <= cur_ptr;
        end
    end

    p_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        good |=> (fetch_valid && fetch_addr == $past(cur_ptr)));

    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        adv_q |-> (ptr_vec[idx_q] == ADDR_W'(ptr_q + ADDR_W'(2))));

    p_bad_plane_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && !good) |=> (fetch_err && !fetch_valid));

    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_en |=> (!fetch_valid && !fetch_err));

    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_en && !wr_hit) |=> $stable(ptr_vec));

    p_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> !fetch_addr[0]);
endmodule

bind bpl_addr_gen bpl_addr_gen_chk #(
    .NUM_PLANES (NUM_PLANES),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_en    (fetch_en),
    .fetch_plane (fetch_plane),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .fetch_err   (fetch_err),
    .wr_hit      (wr_hit),
    .ptr_vec     (ptr_vec)
);

// File: tb/bpl_addr_gen_tb.sv
// Bench: behavioural pointer model compared with the design on every clock.
module bpl_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_long = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        fetch_en = 1'b0;
    logic [2:0]  fetch_plane = '0;
    logic        fetch_valid;
    logic [18:0] fetch_addr;
    logic        fetch_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int model[7];
    bit exp_valid = 1'b0;
    bit exp_err = 1'b0;
    int exp_addr = 0;

    always #2 clk = ~clk;   // 250 MHz

    bpl_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_long(wr_long),
        .wr_addr(wr_addr), .wr_data(wr_data), .fetch_en(fetch_en),
        .fetch_plane(fetch_plane), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .fetch_err(fetch_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model of one clock edge, from the inputs stable before it.
    task automatic model_edge();
        int old[7];
        int p;
        int off;
        foreach (model[i]) old[i] = model[i];
        if (!rst_n) begin
            foreach (model[i]) model[i] = 0;
            exp_valid = 0; exp_err = 0; exp_addr = 0;
            return;
        end
        exp_valid = 0; exp_err = 0;
        if (fetch_en) begin
            p = int'(fetch_plane);
            if (p >= 1 && p <= 6) begin
                exp_valid = 1;
                exp_addr = old[p];
                model[p] = (old[p] + 2) % 524288;
            end else begin
                exp_err = 1;
            end
        end
        if (wr_en && wr_addr >= 9'h0E0 && wr_addr < 9'h0F8 && !wr_addr[0]) begin
            off = int'(wr_addr) - 'h0E0;
            p = off / 4 + 1;
            if (off % 4 == 0) begin
                if (wr_long) model[p] = int'(wr_data[18:0]) & 'h7FFFE;
                else model[p] = (old[p] & 'hFFFF) | (int'(wr_data[2:0]) << 16);
            end else if (!wr_long) begin
                model[p] = (old[p] & 'h70000) | (int'(wr_data[15:0]) & 'hFFFE);
            end
        end
    endtask

    // One clock: update the model at the edge, compare at the falling edge.
    task automatic tick(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(fetch_valid == exp_valid && fetch_err == exp_err &&
              (!exp_valid || int'(fetch_addr) == exp_addr),
              tag, int'({fetch_valid, fetch_err, fetch_addr}),
              (int'(exp_valid) << 20) | (int'(exp_err) << 19) | exp_addr);
        wr_en = 0; wr_long = 0; fetch_en = 0;
    endtask

    task automatic wr(input logic lng, input logic [8:0] a, input logic [31:0] d, input string tag);
        wr_en = 1; wr_long = lng; wr_addr = a; wr_data = d;
        tick(tag);
    endtask

    task automatic fetch(input int p, input string tag);
        fetch_en = 1; fetch_plane = 3'(p);
        tick(tag);
    endtask

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) tick("R1 reset");
        check(!fetch_valid && !fetch_err, "R1 outputs in reset", int'({fetch_valid, fetch_err}), 0);
        rst_n = 1;
        tick("R1 idle");
        fetch(4, "R1 first fetch");
        check(fetch_addr == 19'h0, "R1 pointer zero", int'(fetch_addr), 0);

        // R4: 32-bit loads of planes 1 and 2
        wr(1, 9'h0E0, 32'h0002_1000, "R4 load p1");
        wr(1, 9'h0E4, 32'h0002_5000, "R4 load p2");
        wr(1, 9'h0E6, 32'h0007_7777, "R4 long to low ignored");
        fetch(2, "R4 p2");
        check(fetch_addr == 19'h25000, "R4 long at low ignored", int'(fetch_addr), 'h25000);

        // R2/R3: halves of plane 5
        wr(0, 9'h0F0, 32'h0000_FFFD, "R2 high half");
        wr(0, 9'h0F2, 32'h0000_1235, "R3 low half");
        fetch(5, "R2 R3 p5");
        check(fetch_addr == 19'h51234, "R2 R3 composed pointer", int'(fetch_addr), 'h51234);
        wr(0, 9'h0F2, 32'h0000_0100, "R2 low rewrite");
        fetch(5, "R2 high kept");
        check(fetch_addr == 19'h50100, "R3 high bits kept", int'(fetch_addr), 'h50100);

        // R5: writes outside the block or at odd offsets
        wr(0, 9'h0F8, 32'h0000_0007, "R5 above block");
        wr(0, 9'h0DE, 32'h0000_0007, "R5 below block");
        wr(0, 9'h0F5, 32'h0000_0007, "R5 odd offset");
        fetch(6, "R5 p6");
        check(fetch_addr == 19'h0, "R5 p6 untouched", int'(fetch_addr), 0);

        // R9: invalid plane numbers
        fetch(0, "R9 plane 0");
        check(fetch_err && !fetch_valid, "R9 err on 0", int'({fetch_valid, fetch_err}), 1);
        fetch(7, "R9 plane 7");
        check(fetch_err && !fetch_valid, "R9 err on 7", int'({fetch_valid, fetch_err}), 1);
        tick("R9 err drops");
        check(!fetch_err, "R9 one-cycle pulse", int'(fetch_err), 0);

        // R8: write and fetch to plane 5 in the same cycle
        wr_en = 1; wr_long = 0; wr_addr = 9'h0F2; wr_data = 32'h0000_4000;
        fetch_en = 1; fetch_plane = 3'd5;
        tick("R8 collision");
        check(fetch_addr == 19'h50102, "R8 returns pre-write", int'(fetch_addr), 'h50102);
        fetch(5, "R8 after");
        check(fetch_addr == 19'h54000, "R8 write wins", int'(fetch_addr), 'h54000);

        // R7: wraparound at 19 bits
        wr(1, 9'h0E8, 32'h0007_FFFC, "R7 load p3");
        fetch(3, "R7 a");
        fetch(3, "R7 b");
        check(fetch_addr == 19'h7FFFE, "R7 top word", int'(fetch_addr), 'h7FFFE);
        fetch(3, "R7 c");
        check(fetch_addr == 19'h0, "R7 wrapped", int'(fetch_addr), 0);

        // R10/R11: full plane scans
        wr(1, 9'h0E4, 32'h0002_5000, "R10 reload p2");
        for (int i = 0; i < 4000; i++) begin
            fetch(1, "R10 scan p1");
            if (i == 20) check(fetch_addr == 19'h21028, "R10 second line", int'(fetch_addr), 'h21028);
            if (i == 3999) check(fetch_addr == 19'h22F3E, "R10 last word p1", int'(fetch_addr), 'h22F3E);
        end
        fetch(2, "R11 p2 untouched");
        check(fetch_addr == 19'h25000, "R11 p2 untouched", int'(fetch_addr), 'h25000);
        for (int i = 1; i < 4000; i++) begin
            fetch(2, "R10 scan p2");
            if (i == 3999) check(fetch_addr == 19'h26F3E, "R10 last word p2", int'(fetch_addr), 'h26F3E);
        end
        for (int i = 0; i < 6; i++) fetch(i % 2 + 1, "R11 interleave");

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: an overlong run counts as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule